// File: doc/BRIEF.md
# Endian-Configurable Host Register Port

This block is the slave side of a CPU bus into a small internal register file. The host uses a chip select, separate active-low read and write strobes, an 8-bit register address, a 32-bit data bus and an acknowledge line. The select is shared by up to sixteen devices. Each device compares a 4-bit device address from the bus with its own strapped 4-bit ID. It answers only when the two are equal, and it releases the acknowledge line otherwise.

The port width can be changed at run time to 8, 16 or 32 bits through a configuration byte. One access moves one, two or four register bytes. Those bytes are steered onto the data lanes according to a static endian pin. Lanes outside the active width read as zero, and so do bytes at unused addresses. Writes to unused addresses are dropped. The acknowledge is held low for a fixed number of wait states and then rises. Read data is presented one clock before the acknowledge rises.

Top module: `host_reg_port`

## Requirements
- R1: After reset the port width is 8 bits, every register byte is zero, the acknowledge is low and the read data bus is zero.
- R2: `ack_en_o` is high exactly while `sel_ni` is low, at least one of `rd_ni`/`wr_ni` is low, and `dev_adr_i` equals `dev_id_i`. While it is low, no register changes.
- R3: Take a valid access that appears before rising edge 1 and is held. `ack_o` is low through rising edge WAIT_CYC+2 and high from rising edge WAIT_CYC+3 (edge 5 by default) until the access ends.
- R4: For a read, `rdata_o` holds the addressed data from rising edge WAIT_CYC+2. It stays stable while `ack_o` is high.
- R5: In 8-bit mode an access touches exactly the byte at `reg_adr_i`, carried on access lane 0.
- R6: In 16-bit mode an access touches the bytes at `{reg_adr_i[7:1],0}` and `{reg_adr_i[7:1],1}`. The lower-address byte is on access lane 0.
- R7: In 32-bit mode an access touches the four bytes from `{reg_adr_i[7:2],00}` upward. The lowest-address byte is on access lane 0.
- R8: With `big_end_i` low, access lane j occupies data bits 8j+7:8j. With `big_end_i` high, it occupies bits 31-8j:24-8j.
- R9: Data lanes beyond the active width read as zero. Bytes at unused addresses read as zero, and writes to them are ignored.
- R10: Register map. Address 0x00 is the width byte: bits 1:0 give 00 = 8-bit, 01 = 16-bit, 1x = 32-bit, and the upper bits read 0. There is a 1-byte register at 0x04, a 2-byte register at 0x08–0x09 and a 4-byte register at 0x0C–0x0F. Within a register the lower address holds the less significant byte.
- R11: A width change takes effect from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Shared device select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| reg_adr_i | input | 8 | Register byte address |
| dev_adr_i | input | 4 | Device address from the bus |
| dev_id_i | input | 4 | Strapped device ID |
| big_end_i | input | 1 | Lane order: 0 little, 1 big endian |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| ack_o | output | 1 | Acknowledge: low is wait, high is ready |
| ack_en_o | output | 1 | Acknowledge driven (access matched) |

## Verification
A held access raises the acknowledge on the fifth rising edge after the strobes appear: one synchronizing flop, two wait states, one data stage and one commit stage. Read data is due one edge earlier, on the fourth. A write becomes visible to the next access after release. The bench counts the rising edges for which the decoded match has been true. On every falling edge it compares the acknowledge enable, the acknowledge level and, from edge four on, the read data against a byte-array model. The bench changes pins 1 ns after a falling edge, so each sample sees settled values.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned ADR_W   = 8;
  localparam int unsigned ID_W    = 4;
  localparam int unsigned WIN_B   = 16;
  localparam int unsigned WIN_AW  = $clog2(WIN_B);

  localparam logic [ADR_W-1:0] CFG_ADR = 8'h00;
  localparam logic [ADR_W-1:0] B1_ADR  = 8'h04;
  localparam logic [ADR_W-1:0] B2_ADR  = 8'h08;
  localparam logic [ADR_W-1:0] B4_ADR  = 8'h0C;

  typedef enum logic [1:0] {
    PW_8   = 2'b00,
    PW_16  = 2'b01,
    PW_32  = 2'b10,
    PW_32X = 2'b11
  } port_w_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_DONE
  } hs_st_e;

  typedef logic [LANES-1:0][7:0]       lane_bytes_t;
  typedef logic [LANES-1:0][ADR_W-1:0] lane_adrs_t;

  function automatic logic byte_present(logic [ADR_W-1:0] a);
    return (a == CFG_ADR) || (a == B1_ADR) ||
           (a[ADR_W-1:1] == B2_ADR[ADR_W-1:1]) ||
           (a[ADR_W-1:2] == B4_ADR[ADR_W-1:2]);
  endfunction
endpackage

// File: rtl/hp_access_det.sv
module hp_access_det
  import hp_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_ni,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  logic [ID_W-1:0] dev_adr_i,
  input  logic [ID_W-1:0] dev_id_i,
  output logic            match_o,
  output logic            acc_o
);
  assign match_o = ~sel_ni & (~rd_ni | ~wr_ni) & (dev_adr_i == dev_id_i);

  // strobes are asynchronous to clk_i: sample once before use
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_o <= 1'b0;
    else         acc_o <= match_o;
  end
endmodule

// File: rtl/hp_handshake.sv
module hp_handshake
  import hp_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              rd_ni,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADR_W-1:0]  adr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_o,
  output logic              load_o,
  output logic              commit_o,
  output logic              clr_o,
  output logic              ack_o
);
  localparam int unsigned CNT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

  hs_st_e           st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_wait;

  assign last_wait = (st_q == ST_WAIT) && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      adr_o   <= '0;
      wdata_o <= '0;
      rd_o    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (acc_i) begin
          st_q    <= ST_WAIT;
          cnt_q   <= '0;
          adr_o   <= adr_i;
          wdata_o <= wdata_i;
          rd_o    <= ~rd_ni;
        end
        ST_WAIT: begin
          if (!acc_i)         st_q <= ST_IDLE;
          else if (last_wait) st_q <= ST_XFER;
          else                cnt_q <= cnt_q + 1'b1;
        end
        ST_XFER: st_q <= acc_i ? ST_DONE : ST_IDLE;
        ST_DONE: if (!acc_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o   = last_wait & acc_i & rd_o;
  assign commit_o = (st_q == ST_XFER) & acc_i & ~rd_o;
  assign clr_o    = (st_q == ST_IDLE);
  assign ack_o    = (st_q == ST_DONE);

  // R3
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(acc_i));
endmodule

// File: rtl/hp_lane_map.sv
module hp_lane_map
  import hp_pkg::*;
(
  input  port_w_e           width_i,
  input  logic              big_end_i,
  input  logic [ADR_W-1:0]  adr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  lane_bytes_t       rd_bytes_i,
  output lane_adrs_t        lane_adr_o,
  output logic [LANES-1:0]  lane_en_o,
  output lane_bytes_t       wr_bytes_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [2:0]       nbytes;
  logic [ADR_W-1:0] base;
  lane_bytes_t      rd_masked;

  always_comb begin
    unique case (width_i)
      PW_8:    begin nbytes = 3'd1; base = adr_i; end
      PW_16:   begin nbytes = 3'd2; base = {adr_i[ADR_W-1:1], 1'b0}; end
      default: begin nbytes = 3'd4; base = {adr_i[ADR_W-1:2], 2'b00}; end
    endcase
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int unsigned LE_LO = 8 * j;
    localparam int unsigned BE_LO = 8 * (LANES - 1 - j);
    assign lane_adr_o[j] = base + ADR_W'(j);
    assign lane_en_o[j]  = (3'(j) < nbytes);
    assign wr_bytes_o[j] = big_end_i ? wdata_i[BE_LO +: 8] : wdata_i[LE_LO +: 8];
    assign rd_masked[j]  = lane_en_o[j] ? rd_bytes_i[j] : 8'h00;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_pos
    assign rdata_o[8*k +: 8] = big_end_i ? rd_masked[LANES-1-k] : rd_masked[k];
  end
endmodule

// File: rtl/hp_regbank.sv
module hp_regbank
  import hp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  lane_adrs_t       lane_adr_i,
  input  logic [LANES-1:0] lane_en_i,
  input  lane_bytes_t      wr_bytes_i,
  output lane_bytes_t      rd_bytes_o,
  output port_w_e          width_o
);
  logic [WIN_B-1:0][7:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (commit_i) begin
      for (int j = 0; j < LANES; j++) begin
        if (lane_en_i[j] && byte_present(lane_adr_i[j])) begin
          if (lane_adr_i[j] == CFG_ADR)
            mem_q[lane_adr_i[j][WIN_AW-1:0]] <= {6'b0, wr_bytes_i[j][1:0]};
          else
            mem_q[lane_adr_i[j][WIN_AW-1:0]] <= wr_bytes_i[j];
        end
      end
    end
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      rd_bytes_o[j] = byte_present(lane_adr_i[j]) ? mem_q[lane_adr_i[j][WIN_AW-1:0]] : 8'h00;
    end
  end

  assign width_o = port_w_e'(mem_q[CFG_ADR[WIN_AW-1:0]][1:0]);

  // R2
  store_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_q) |-> $past(commit_i));
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hp_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_ni,
  input  logic        rd_ni,
  input  logic        wr_ni,
  input  logic [7:0]  reg_adr_i,
  input  logic [3:0]  dev_adr_i,
  input  logic [3:0]  dev_id_i,
  input  logic        big_end_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        ack_o,
  output logic        ack_en_o
);
  logic              acc;
  logic [ADR_W-1:0]  adr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rd_q, load, commit, clr;
  port_w_e           width;
  lane_adrs_t        lane_adr;
  logic [LANES-1:0]  lane_en;
  lane_bytes_t       wr_bytes, rd_bytes;
  logic [DATA_W-1:0] map_rdata, rdata_q;

  hp_access_det u_det (
    .clk_i, .rst_ni, .sel_ni, .rd_ni, .wr_ni,
    .dev_adr_i, .dev_id_i,
    .match_o (ack_en_o),
    .acc_o   (acc)
  );

  hp_handshake #(.WAIT_CYC(WAIT_CYC)) u_hs (
    .clk_i, .rst_ni,
    .acc_i    (acc),
    .rd_ni,
    .adr_i    (reg_adr_i),
    .wdata_i,
    .adr_o    (adr_q),
    .wdata_o  (wdata_q),
    .rd_o     (rd_q),
    .load_o   (load),
    .commit_o (commit),
    .clr_o    (clr),
    .ack_o
  );

  hp_lane_map u_map (
    .width_i    (width),
    .big_end_i,
    .adr_i      (adr_q),
    .wdata_i    (wdata_q),
    .rd_bytes_i (rd_bytes),
    .lane_adr_o (lane_adr),
    .lane_en_o  (lane_en),
    .wr_bytes_o (wr_bytes),
    .rdata_o    (map_rdata)
  );

  hp_regbank u_bank (
    .clk_i, .rst_ni,
    .commit_i   (commit),
    .lane_adr_i (lane_adr),
    .lane_en_i  (lane_en),
    .wr_bytes_i (wr_bytes),
    .rd_bytes_o (rd_bytes),
    .width_o    (width)
  );

  // data registered one cycle ahead of the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (clr)  rdata_q <= '0;
    else if (load) rdata_q <= map_rdata;
  end

  assign rdata_o = rdata_q;

  // R4
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && $past(ack_o)) |-> $stable(rdata_o));

  // R9
  zero_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && rd_q && width == PW_8 && !big_end_i) |-> (rdata_o[31:8] == 24'h0));
endmodule

// File: tb/sim_host_reg_port.sv
module sim_host_reg_port;
  localparam int WAIT_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  reg_adr = '0;
  logic [3:0]  dev_adr = 4'h3, dev_id = 4'h3;
  logic        big_end = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, ack_en;

  int checks = 0, errors = 0, cnt = 0, cyc = 0;
  int mdl_w = 1;
  logic [7:0]  mdl [256];
  logic [31:0] exp_rd = '0;
  bit          chk_rd = 0;
  string       tag = "";

  always #2.5 clk = ~clk;

  host_reg_port #(.WAIT_CYC(WAIT_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .reg_adr_i(reg_adr), .dev_adr_i(dev_adr), .dev_id_i(dev_id),
    .big_end_i(big_end), .wdata_i(wdata), .rdata_o(rdata),
    .ack_o(ack), .ack_en_o(ack_en)
  );

  function automatic bit present(int a);
    return a == 0 || a == 4 || a == 8 || a == 9 || (a >= 12 && a <= 15);
  endfunction

  function automatic int base_of(int a);
    return a - (a % mdl_w);
  endfunction

  function automatic logic [31:0] mdl_read(int a);
    logic [31:0] r = '0;
    for (int j = 0; j < mdl_w; j++) begin
      logic [7:0] b = present(base_of(a) + j) ? mdl[base_of(a) + j] : 8'h00;
      if (big_end) r[8*(3-j) +: 8] = b;
      else         r[8*j +: 8]     = b;
    end
    return r;
  endfunction

  task automatic mdl_write(int a, logic [31:0] d);
    for (int j = 0; j < mdl_w; j++) begin
      int x = base_of(a) + j;
      logic [7:0] b = big_end ? d[8*(3-j) +: 8] : d[8*j +: 8];
      if (present(x)) mdl[x] = (x == 0) ? (b & 8'h03) : b;
    end
    mdl_w = (mdl[0][1:0] == 2'b00) ? 1 : (mdl[0][1:0] == 2'b01) ? 2 : 4;
  endtask

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic bit v_now();
    return !sel_n && (!rd_n || !wr_n) && dev_adr == dev_id;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) cnt = 0;
    else        cnt = v_now() ? cnt + 1 : 0;
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ack == 1'b0 && rdata == 32'h0, "R1 reset outputs", {ack, rdata[30:0]}, 32'h0);
    end else begin
      chk(ack_en == v_now(), "R2 ack_en decode", 32'(ack_en), 32'(v_now()));
      if (v_now()) begin
        chk(ack == (cnt >= WAIT_CYC + 3), "R3 ack timing", 32'(ack), 32'(cnt >= WAIT_CYC + 3));
        if (chk_rd && cnt >= WAIT_CYC + 2)
          chk(rdata == exp_rd, {"R4 read data ", tag}, rdata, exp_rd);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic access(bit rd, logic [7:0] a, logic [31:0] d, string t);
    @(negedge clk); #1;
    if (rd) begin exp_rd = mdl_read(int'(a)); chk_rd = 1; tag = t; end
    reg_adr = a; wdata = d; sel_n = 1'b0; rd_n = !rd; wr_n = rd;
    repeat (WAIT_CYC + 4) @(negedge clk);
    #1;
    sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; chk_rd = 0;
    if (!rd) mdl_write(int'(a), d);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_(logic [7:0] a, string t); access(1, a, 32'h0, t); endtask
  task automatic wr_(logic [7:0] a, logic [31:0] d); access(0, a, d, "write"); endtask

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: defaults after reset, 8-bit mode
    rd_(8'h00, "R1 cfg after reset");
    rd_(8'h0F, "R1 byte after reset");

    // R5 R8 R10: byte writes, little endian
    wr_(8'h0C, 32'h11); wr_(8'h0D, 32'h22); wr_(8'h0E, 32'h33); wr_(8'h0F, 32'h44);
    wr_(8'h04, 32'hA5); wr_(8'h08, 32'h5A); wr_(8'h09, 32'hC3);
    rd_(8'h0C, "R5 byte 0C"); rd_(8'h0F, "R5 byte 0F");
    rd_(8'h04, "R10 1-byte reg"); rd_(8'h09, "R10 2-byte reg hi");

    // R9: reserved byte
    wr_(8'h05, 32'hFF); rd_(8'h05, "R9 reserved read");
    rd_(8'h40, "R9 far reserved");

    // R8: big endian in 8-bit mode
    big_end = 1'b1;
    rd_(8'h0D, "R8 BE 8-bit");
    wr_(8'h04, 32'h7E00_0000); rd_(8'h04, "R8 BE write");
    big_end = 1'b0;

    // R6 R10 R11: 16-bit mode, upper cfg bits discarded
    wr_(8'h00, 32'hFD);
    rd_(8'h00, "R10 cfg upper bits zero");
    rd_(8'h08, "R6 half 08"); rd_(8'h09, "R6 half via odd addr");
    rd_(8'h04, "R9 16-bit partner reserved"); rd_(8'h0E, "R6 half 0E");
    big_end = 1'b1;
    rd_(8'h0C, "R8 BE 16-bit");
    wr_(8'h0E, 32'hABCD_0000);
    big_end = 1'b0;
    rd_(8'h0E, "R6 LE after BE write");

    // R7 R11: 32-bit mode
    wr_(8'h00, 32'h0000_0002);
    rd_(8'h0C, "R7 word 0C"); rd_(8'h0D, "R7 unaligned addr");
    rd_(8'h08, "R9 32-bit 2-byte reg"); rd_(8'h00, "R7 cfg word");
    big_end = 1'b1;
    rd_(8'h0C, "R8 BE 32-bit"); rd_(8'h04, "R9 BE zero fill");
    big_end = 1'b0;
    wr_(8'h0C, 32'hDEAD_BEEF); rd_(8'h0C, "R7 word write");

    // R2: mismatched ID and no strobe, then different strapped ID
    @(negedge clk); #1;
    dev_adr = 4'h4; reg_adr = 8'h0C; wdata = 32'h0; sel_n = 1'b0; wr_n = 1'b0;
    repeat (8) @(negedge clk); #1;
    sel_n = 1'b1; wr_n = 1'b1; dev_adr = 4'h3;
    repeat (2) @(negedge clk); #1;
    sel_n = 1'b0;
    repeat (8) @(negedge clk); #1;
    sel_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_(8'h0C, "R2 no write on mismatch");
    dev_id = 4'h9; dev_adr = 4'h9;
    rd_(8'h0C, "R2 other ID match");

    // R10 R11: code 11 is 32-bit, then back to 8-bit
    wr_(8'h00, 32'h0000_0003); rd_(8'h0C, "R10 cfg 11 is 32-bit");
    wr_(8'h00, 32'h0000_0000); rd_(8'h0F, "R11 back to 8-bit");
    rd_(8'h01, "R9 8-bit reserved");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule